// File: doc/BRIEF.md
# Repetitive-Addition Multiplier

This block forms the unsigned product of two operands using only one adder. After a command it copies the multiplicand into a working register and the multiplier into a down-counter. It clears the accumulator. It then adds the multiplicand to the accumulator once per clock, counting the multiplier down, until the counter reaches zero. When either operand is zero, the adding loop is skipped and the product is set to zero straight away.

The block is split into a controller and a datapath. The datapath reports three status flags: multiplicand is zero, multiplier is zero, and next count is zero. The controller uses these flags to choose its next state and to drive the register controls. A host waits for `ready`, presents both operands and pulses `start` for one cycle. The product stays on `r` until the next accepted command.

Top module: `rpt_add_mul`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle. After that edge `ready` is 1 and `r` is 0.
- R2: A command is accepted only at an edge where `ready` and `start` are both 1. `ready` is 0 after that edge.
- R3: If either operand is 0 when a command is accepted, `ready` stays low for exactly one cycle. It then returns high with `r` equal to 0.
- R4: If both operands are non-zero, `r` reads 0 after the second edge following acceptance, while `ready` is still low.
- R5: When `ready` returns high, `r` equals the 16-bit unsigned product of the operands that were accepted. Exactly as many additions are made as the multiplier's value.
- R6: For non-zero operands, `ready` stays low for exactly `b_in` + 1 cycles.
- R7: While `ready` is high and `start` is low, `r` and `ready` keep their values.
- R8: A `start` pulse or an operand change while `ready` is low has no effect on the result or on the latency.
- R9: The full operand range is covered: 255 × 255 gives 65025 with no overflow of `r`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Command pulse, sampled only while `ready` is high |
| a_in | input | 8 | Multiplicand, unsigned |
| b_in | input | 8 | Multiplier, unsigned; also sets the loop count |
| r | output | 16 | Product, held until the next command |
| ready | output | 1 | High when idle and able to accept a command |

## Verification
The results come due on different cycles:
- The busy indication falls on the first edge after acceptance.
- For a non-zero pair, the cleared accumulator appears after the second edge.
- The final product arrives when `ready` rises: one cycle after acceptance for a zero operand, and `b_in` + 1 cycles after it otherwise.

The monitor samples at the falling edge and counts every cycle in which `ready` is low. When `ready` rises, it compares that count and `r` against the item queued by the driver. Stray commands and operand changes are issued while the block is busy, and the product is then expected to stay unchanged. Idle stretches are checked to confirm that the held product does not move.

// File: rtl/rpt_add_pkg.sv
// Package: shared types for the repetitive-addition multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package rpt_add_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ZERO = 2'd1,
        ST_LOAD = 2'd2,
        ST_OP   = 2'd3
    } ctl_state_t;

    // Datapath control bundle driven by the controller
    typedef struct packed {
        logic ld_ops;   // capture operands into a and n
        logic clr_acc;  // clear the accumulator
        logic add_dec;  // acc += a, n -= 1
    } dp_ctl_t;

endpackage

// File: rtl/rpt_add_cnt.sv
// Module: down-counter for the multiplier.
// What it does: loads a value on request and decrements it on request.
// It flags when the decremented value would be zero.
// Assumes: load and decrement are never requested together.
module rpt_add_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] load_val,
    output logic         next_zero
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_dec;

    // Value the counter takes after one decrement
    always_comb begin
        cnt_dec   = cnt_q - {{(W-1){1'b0}}, 1'b1};
        next_zero = (cnt_dec == '0);
    end

    // Counter register: load, decrement or hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec)
            cnt_q <= cnt_dec;
    end

endmodule

// File: rtl/rpt_add_dp.sv
// Module: datapath for the repetitive-addition multiplier.
// What it does: holds the multiplicand, the count and the accumulator,
// and reports the status flags used by the controller.
// Assumes: the controls are mutually exclusive as issued by rpt_add_ctrl.
module rpt_add_dp
    import rpt_add_pkg::*;
#(
    parameter int OP_W = 8,
    localparam int PW  = 2 * OP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  dp_ctl_t         ctl,
    input  logic [OP_W-1:0] a_in,
    input  logic [OP_W-1:0] b_in,
    output logic            a_zero,
    output logic            b_zero,
    output logic            cnt_zero,
    output logic [PW-1:0]   acc
);

    logic [OP_W-1:0] mcand_q;
    logic [PW-1:0]   acc_q;
    logic [PW-1:0]   acc_sum;

    // Status flags taken from the operand inputs
    always_comb begin
        a_zero = (a_in == '0);
        b_zero = (b_in == '0);
    end

    // The single shared adder
    always_comb acc_sum = acc_q + {{(PW-OP_W){1'b0}}, mcand_q};

    // Multiplicand register
    always_ff @(posedge clk) begin
        if (!rst_n)
            mcand_q <= '0;
        else if (ctl.ld_ops)
            mcand_q <= a_in;
    end

    // Accumulator: clear, add or hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (ctl.clr_acc)
            acc_q <= '0;
        else if (ctl.add_dec)
            acc_q <= acc_sum;
    end

    rpt_add_cnt #(.W(OP_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctl.ld_ops),
        .dec       (ctl.add_dec),
        .load_val  (b_in),
        .next_zero (cnt_zero)
    );

    assign acc = acc_q;

endmodule

// File: rtl/rpt_add_ctrl.sv
// Module: controller for the repetitive-addition multiplier.
// What it does: sequences idle, zero-shortcut, load and add-loop states.
// It does so from start and the datapath flags.
// Assumes: the flags are valid in the same cycle they are sampled.
module rpt_add_ctrl
    import rpt_add_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    a_zero,
    input  logic    b_zero,
    input  logic    cnt_zero,
    output logic    ready,
    output dp_ctl_t ctl
);

    ctl_state_t st_q, st_d;

    // Next-state and control decode
    always_comb begin
        st_d        = st_q;
        ctl         = '0;
        ready       = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                ready = 1'b1;
                if (start) begin
                    ctl.ld_ops = 1'b1;
                    st_d = (a_zero || b_zero) ? ST_ZERO : ST_LOAD;
                end
            end
            ST_ZERO: begin
                ctl.clr_acc = 1'b1;
                st_d = ST_IDLE;
            end
            ST_LOAD: begin
                ctl.clr_acc = 1'b1;
                st_d = ST_OP;
            end
            ST_OP: begin
                ctl.add_dec = 1'b1;
                if (cnt_zero)
                    st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/rpt_add_mul.sv
// Module: top of the repetitive-addition multiplier.
// What it does: joins the controller and the datapath.
// Assumes: the host pulses start only while ready is high; other pulses are ignored.
module rpt_add_mul
    import rpt_add_pkg::*;
#(
    parameter int OP_W = 8,
    localparam int PW  = 2 * OP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [OP_W-1:0] a_in,
    input  logic [OP_W-1:0] b_in,
    output logic [PW-1:0]   r,
    output logic            ready
);

    dp_ctl_t ctl;
    logic    a_zero, b_zero, cnt_zero;

    rpt_add_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .a_zero   (a_zero),
        .b_zero   (b_zero),
        .cnt_zero (cnt_zero),
        .ready    (ready),
        .ctl      (ctl)
    );

    rpt_add_dp #(.OP_W(OP_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .a_in     (a_in),
        .b_in     (b_in),
        .a_zero   (a_zero),
        .b_zero   (b_zero),
        .cnt_zero (cnt_zero),
        .acc      (r)
    );

endmodule

// File: rtl/rpt_add_mul_chk.sv
// Module: assertion checker for rpt_add_mul, bound to the top.
// What it does: checks the port-level timing and a product model.
// Assumes: it observes the top's ports only.
module rpt_add_mul_chk #(
    parameter int OP_W = 8,
    localparam int PW  = 2 * OP_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [OP_W-1:0] a_in,
    input logic [OP_W-1:0] b_in,
    input logic [PW-1:0]   r,
    input logic            ready
);

    logic [OP_W-1:0] cap_a, cap_b;
    logic [OP_W:0]   busy_cnt;
    logic            armed;

    // Operand capture and busy-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a    <= '0;
            cap_b    <= '0;
            busy_cnt <= '0;
            armed    <= 1'b0;
        end else if (ready && start) begin
            cap_a    <= a_in;
            cap_b    <= b_in;
            busy_cnt <= '0;
            armed    <= 1'b1;
        end else if (!ready) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (ready && r == '0));

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> !ready);

    assert_zero_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start && (a_in == '0 || b_in == '0)) |=> !ready ##1 (ready && r == '0));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start && a_in != '0 && b_in != '0) |=> !ready ##1 (!ready && r == '0));

    assert_product_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && armed) |-> (r == PW'(cap_a) * PW'(cap_b)));

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && armed && cap_a != '0 && cap_b != '0)
            |-> (busy_cnt == {1'b0, cap_b} + 1'b1));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> (ready && $stable(r)));

endmodule

bind rpt_add_mul rpt_add_mul_chk #(.OP_W(OP_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .a_in  (a_in),
    .b_in  (b_in),
    .r     (r),
    .ready (ready)
);

// File: tb/rpt_add_mul_tb.sv
module rpt_add_mul_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  a_in = '0;
    logic [7:0]  b_in = '0;
    logic [15:0] r;
    logic        ready;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [15:0] exp_prod_q[$];
    int          exp_lat_q[$];

    always #2.5 clk = ~clk;

    rpt_add_mul u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_in(a_in), .b_in(b_in), .r(r), .ready(ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: issue one command and push its expected result
    task automatic issue(input logic [7:0] a, input logic [7:0] b, input bit stray);
        while (!ready) @(negedge clk);
        a_in  = a;
        b_in  = b;
        start = 1'b1;
        exp_prod_q.push_back(16'(a) * 16'(b));
        exp_lat_q.push_back((a == 0 || b == 0) ? 1 : int'(b) + 1);
        @(negedge clk);
        start = 1'b0;
        check(ready == 1'b0, "R2", int'(ready), 0);
        if (a != 0 && b != 0) begin
            @(negedge clk);
            check(r == 16'd0 && !ready, "R4", int'(r), 0);
            if (stray && b > 4) begin
                // R8: stray command and operand churn while busy
                start = 1'b1; a_in = 8'd3; b_in = 8'd0;
                @(negedge clk);
                a_in = 8'd77; b_in = 8'd200;
                @(negedge clk);
                start = 1'b0;
            end
        end
        while (!ready) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: count busy cycles and compare on completion
    initial begin
        int low = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                low = 0;
            end else if (!ready) begin
                low++;
            end else if (low > 0) begin
                if (exp_prod_q.size() == 0) begin
                    check(1'b0, "R5", int'(r), -1);
                end else begin
                    logic [15:0] ep;
                    int el;
                    ep = exp_prod_q.pop_front();
                    el = exp_lat_q.pop_front();
                    check(r == ep, "R5/R3/R9 product", int'(r), int'(ep));
                    check(low == el, "R6/R3/R8 latency", low, el);
                end
                low = 0;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        check(ready == 1'b1 && r == 16'd0, "R1 reset", int'(r), 0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(8'd7, 8'd5, 1'b0);
        issue(8'd0, 8'd9, 1'b0);      // R3
        issue(8'd12, 8'd0, 1'b0);     // R3
        issue(8'd1, 8'd1, 1'b0);
        issue(8'd200, 8'd3, 1'b0);
        issue(8'd13, 8'd20, 1'b1);    // R8
        issue(8'd255, 8'd255, 1'b0);  // R9

        // R7: hold while idle
        held = r;
        repeat (10) @(negedge clk);
        check(r == held && ready, "R7 hold", int'(r), int'(held));

        // R1: reset in the middle of a run
        a_in = 8'd90; b_in = 8'd40; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(ready == 1'b1 && r == 16'd0, "R1 mid-run reset", int'(r), 0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(8'd9, 8'd14, 1'b1);     // R8
        issue(8'd255, 8'd1, 1'b0);
        repeat (3) @(negedge clk);
        check(exp_prod_q.size() == 0, "R5 all results seen", exp_prod_q.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule